// File: doc/BRIEF.md
# Dual Wiper Register Serial Slave

This block is a two-wire serial bus slave that keeps the digital state of a dual-channel variable resistor. It holds two 8-bit wiper codes and one shutdown flag per channel. The block samples the bus clock and data lines with the system clock. Each line passes through a two-stage synchroniser and a persistence filter before start, stop and clock edges are detected. A control state machine receives the address byte. For a write it then receives an instruction byte, followed by any number of code bytes. For a read it returns the code of the channel that is currently pointed at. The slave only pulls the data line low; `sda_oe` high means drive low.

A write transfer is: start, address with R/W = 0, instruction byte, then zero or more code bytes, each acknowledged, then stop. Instruction bit 7 picks the channel and bit 6 is the shutdown flag for that channel. The pointer to the picked channel stays in place until another instruction changes it, and later reads use it. A channel in shutdown reports terminal A open and its wiper at the B end: its effective code is 0x00. Its stored code is kept, and it can still be rewritten while shut down.

The states are IDLE, ADDR, ADDR_ACK, INSTR, INSTR_ACK, DATA, DATA_ACK, RD_BYTE, RD_ACK and IGNORE. A stop takes any state to IDLE, and a start takes any state to ADDR.
- ADDR goes to ADDR_ACK on a matching address, or to IGNORE otherwise.
- ADDR_ACK goes to RD_BYTE on a read, or to INSTR on a write.
- INSTR goes to INSTR_ACK, which goes to DATA.
- DATA goes to DATA_ACK, which goes back to DATA.
- RD_BYTE goes to RD_ACK.
- RD_ACK goes back to RD_BYTE on a master ACK, or to IGNORE on a NACK.

Every move away from a byte or acknowledge state happens on a falling edge of the filtered bus clock.

Top module: `dual_wiper_i2c_slave`

## Requirements
- R1: After reset both wiper codes read 0x80, both shutdown flags are clear, and `sda_oe` is low.
- R2: The slave acknowledges only the 7-bit address {0,1,0,1,1,`strap_a1`,`strap_a0`}, sent MSB first with the R/W bit last. For any other address it neither acknowledges nor acts on later bytes until the next start.
- R3: In a write, the byte after the address is acknowledged. Its bit 7 selects the channel (0 gives channel 1, 1 gives channel 2), its bit 6 sets or clears that channel's shutdown flag, and bits 5:0 have no effect.
- R4: Every code byte that follows the instruction in the same write is acknowledged and overwrites the selected channel's stored code, MSB first.
- R5: A read returns, MSB first and directly after the address acknowledge, the stored code of the channel last selected by an instruction. The selection persists across transfers.
- R6: While the master acknowledges read bytes, the slave keeps sending the selected code. After a master NACK it releases the data line until the next start or stop.
- R7: While a channel's shutdown flag is set, its effective code is 0x00 and its `chan_shutdown` bit is 1. The stored code is kept and still accepts writes, and the stored value appears when the flag is cleared.
- R8: A start (data falling while clock high) restarts address reception from any state, including a repeated start in the middle of a transfer. The slave changes its data drive only while the filtered clock is low.
- R9: A pulse on a bus line shorter than FILT_LEN system clocks is filtered out and creates no start, stop or edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls the data line low |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| strap_a0 | input | 1 | Address strap, address bit 0 |
| wiper1_code | output | 8 | Effective code of channel 1 |
| wiper2_code | output | 8 | Effective code of channel 2 |
| chan_shutdown | output | 2 | Bit n-1 high: channel n has A open and the wiper at B |

## Verification
The assertions check several rules on every cycle. The filtered line value changes only after the synchronised input has agreed with it. The data drive changes only while the filtered clock is low, and it is never asserted in IGNORE. Stored codes and the channel pointer change only on their write strobes.

Other behaviour needs whole transfers, and only the bench's scenarios can show it. These are address matching across all 128 addresses and every strap setting, multi-byte overwrites over a sweep of codes, and the sticky read pointer. They also cover shutdown masking with a hidden rewrite, repeated starts, the NACK release, and the rejection of a one-cycle false stop.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] ADDR_PREFIX = 5'b01011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_t;

endpackage

// File: rtl/glitch_filter.sv
module glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FW-1:0]          run_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // bus lines idle high, so the synchroniser resets to one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    // the clean value follows only after FILT_LEN disagreeing samples in a row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean <= 1'b1;
            run_q <= '0;
        end else if (synced == clean) begin
            run_q <= '0;
        end else if (run_q == FW'(FILT_LEN - 1)) begin
            clean <= synced;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9: the output moves only toward a value the synchroniser already held
    p_filter_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> ($past(synced) == clean));

endmodule

// File: rtl/line_conditioner.sv
module line_conditioner #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    logic             scl_prev;
    logic             sda_prev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    assign scl_f = clean_lines[0];
    assign sda_f = clean_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_f;
            sda_prev <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_prev;
    assign scl_fall  = ~scl_f & scl_prev;
    assign start_det = scl_f & scl_prev & sda_prev & ~sda_f;
    assign stop_det  = scl_f & scl_prev & ~sda_prev & sda_f;

endmodule

// File: rtl/link_fsm.sv
module link_fsm
    import wiper_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_code,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              instr_en,
    output logic              instr_sel,
    output logic              instr_shdn
);
    link_state_t       state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              mack_q;
    logic              byte_done;
    logic              addr_hit;

    assign byte_done = scl_fall && (bitcnt_q == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == {ADDR_PREFIX, strap});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: stop and start take priority over all else
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_d = shreg_q[0] ? ST_RD_BYTE : ST_INSTR;
                ST_INSTR:     if (byte_done) state_d = ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall) state_d = ST_DATA;
                ST_DATA:      if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_RD_BYTE:   if (scl_fall && bitcnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter and master acknowledge capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            mack_q   <= 1'b0;
        end else if (start_det) begin
            bitcnt_q <= '0;
        end else if (state_d != state_q) begin
            bitcnt_q <= '0;
            if (state_d == ST_RD_BYTE) shreg_q <= rd_code;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise && bitcnt_q < CNT_W'(BYTE_W)) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b1};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                end
                ST_IDLE, ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK, ST_IGNORE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe     = 1'b0;
        wr_en      = 1'b0;
        instr_en   = 1'b0;
        wr_data    = shreg_q;
        instr_sel  = shreg_q[BYTE_W-1];
        instr_shdn = shreg_q[BYTE_W-2];
        unique case (state_q)
            ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_RD_BYTE: sda_oe = ~shreg_q[BYTE_W-1];
            ST_INSTR:   instr_en = (state_d == ST_INSTR_ACK);
            ST_DATA:    wr_en = (state_d == ST_DATA_ACK);
            ST_IDLE, ST_ADDR, ST_RD_ACK, ST_IGNORE: begin
            end
            default: begin
            end
        endcase
    end

    // R8: the data drive only moves while the filtered clock is low
    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // R2: no drive after an address mismatch or a read NACK
    p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe);

    // R6: a NACKed read byte leads to the released state
    p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && scl_fall && !mack_q && !start_det && !stop_det)
        |=> !sda_oe);

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int               CH         = 2,
    parameter int               W          = 8,
    parameter logic [W-1:0]     RESET_CODE = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_en,
    input  logic [$clog2(CH)-1:0] instr_sel,
    input  logic                  instr_shdn,
    input  logic                  wr_en,
    input  logic [W-1:0]          wr_data,
    output logic [W-1:0]          rd_code,
    output logic [CH-1:0][W-1:0]  eff_code,
    output logic [CH-1:0]         shdn
);
    localparam int SW = $clog2(CH);

    logic [CH-1:0][W-1:0] code_q;
    logic [SW-1:0]        ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            shdn  <= '0;
        end else if (instr_en) begin
            ptr_q             <= instr_sel;
            shdn[instr_sel]   <= instr_shdn;
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          code_q[c] <= RESET_CODE;
            else if (wr_en && ptr_q == SW'(c))   code_q[c] <= wr_data;
        end
        assign eff_code[c] = shdn[c] ? '0 : code_q[c];
    end

    assign rd_code = code_q[ptr_q];

    // R4: stored codes change only on a write strobe
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_q));

    // R5: the read pointer changes only on an instruction strobe
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_en |=> $stable(ptr_q));

endmodule

// File: rtl/dual_wiper_i2c_slave.sv
module dual_wiper_i2c_slave
    import wiper_i2c_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                FILT_LEN    = 3,
    parameter logic [BYTE_W-1:0] RESET_CODE  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_a1,
    input  logic              strap_a0,
    output logic [BYTE_W-1:0] wiper1_code,
    output logic [BYTE_W-1:0] wiper2_code,
    output logic [1:0]        chan_shutdown
);
    localparam int CH = 2;

    logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en, instr_en, instr_sel, instr_shdn;
    logic [BYTE_W-1:0]        wr_data, rd_code;
    logic [CH-1:0][BYTE_W-1:0] eff_code;

    line_conditioner #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    link_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     ({strap_a1, strap_a0}),
        .rd_code   (rd_code),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .instr_en  (instr_en),
        .instr_sel (instr_sel),
        .instr_shdn(instr_shdn)
    );

    wiper_bank #(
        .CH        (CH),
        .W         (BYTE_W),
        .RESET_CODE(RESET_CODE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_en  (instr_en),
        .instr_sel (instr_sel),
        .instr_shdn(instr_shdn),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_code   (rd_code),
        .eff_code  (eff_code),
        .shdn      (chan_shutdown)
    );

    assign wiper1_code = eff_code[0];
    assign wiper2_code = eff_code[1];

endmodule

// File: tb/sim_dual_wiper_i2c_slave.sv
module sim_dual_wiper_i2c_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap_a1 = 1'b1;
    logic strap_a0 = 1'b0;
    logic sda_oe;
    logic [7:0] wiper1_code, wiper2_code;
    logic [1:0] chan_shutdown;
    wire  sda_bus = sda_m & ~sda_oe;

    int nchk = 0;
    int nfail = 0;

    logic [7:0] exp_code [2];
    logic       exp_sd   [2];
    int         exp_ptr;

    always #2.5 clk = ~clk;

    dual_wiper_i2c_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe       (sda_oe),
        .strap_a1     (strap_a1),
        .strap_a0     (strap_a0),
        .wiper1_code  (wiper1_code),
        .wiper2_code  (wiper2_code),
        .chan_shutdown(chan_shutdown)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] eff(int c);
        return exp_sd[c] ? 8'h00 : exp_code[c];
    endfunction

    task automatic chk_outs(string req);
        chk(wiper1_code == eff(0), req, "wiper1", wiper1_code, eff(0));
        chk(wiper2_code == eff(1), req, "wiper2", wiper2_code, eff(1));
        chk(chan_shutdown == {exp_sd[1], exp_sd[0]}, req, "shutdown",
            chan_shutdown, {exp_sd[1], exp_sd[0]});
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(bit b, bit glitch);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        if (glitch) begin
            sda_m = ~b; tick(1);
            sda_m = b;  tick(Q - 1);
        end else begin
            tick(Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int glitch_bit, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], i == glitch_bit);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit master_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~master_ack, 1'b0);
    endtask

    function automatic logic [6:0] own_addr();
        return {5'b01011, strap_a1, strap_a0};
    endfunction

    // instruction byte: bit 7 channel, bit 6 shutdown, bits 5:0 junk
    task automatic apply_instr(logic [7:0] ins);
        exp_ptr = ins[7];
        exp_sd[ins[7]] = ins[6];
    endtask

    task automatic write_instr(logic [7:0] ins, string req);
        bit ack;
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        chk(ack, "R2", "addr ack", ack, 1);
        send_byte(ins, -1, ack);
        chk(ack, req, "instr ack", ack, 1);
        apply_instr(ins);
        bus_stop();
        tick(4);
    endtask

    task automatic read_check(string req, int nbytes);
        bit ack, b;
        logic [7:0] v;
        bus_start();
        send_byte({own_addr(), 1'b1}, -1, ack);
        chk(ack, "R2", "read addr ack", ack, 1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(v, k != nbytes - 1);
            chk(v == exp_code[exp_ptr], req, "read data", v, exp_code[exp_ptr]);
        end
        // R6: after the NACK the line stays released
        for (int k = 0; k < 2; k++) begin
            get_bit(b);
            chk(b == 1'b1, "R6", "released after nack", b, 1);
        end
        bus_stop();
        tick(4);
    endtask

    initial begin
        bit ack;
        exp_code[0] = 8'h80; exp_code[1] = 8'h80;
        exp_sd[0] = 1'b0;    exp_sd[1] = 1'b0;
        exp_ptr = 0;
        tick(5);
        rst_n = 1'b1;
        tick(10);

        // R1 reset state
        chk_outs("R1");
        chk(sda_oe == 1'b0, "R1", "sda_oe", sda_oe, 0);

        // R2 full address sweep with straps 1,0
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, -1, ack);
            bus_stop();
            chk(ack == (a[6:0] == own_addr()), "R2", "addr sweep", a, own_addr());
        end
        chk_outs("R2");

        // R2 every strap setting: own address hits, neighbour misses
        for (int s = 0; s < 4; s++) begin
            strap_a1 = s[1]; strap_a0 = s[0];
            tick(4);
            bus_start();
            send_byte({own_addr(), 1'b0}, -1, ack);
            bus_stop();
            chk(ack, "R2", "strap hit", s, 1);
            bus_start();
            send_byte({own_addr() ^ 7'h01, 1'b0}, -1, ack);
            bus_stop();
            chk(!ack, "R2", "strap miss", s, 0);
        end
        strap_a1 = 1'b1; strap_a0 = 1'b0;
        tick(4);

        // R3 R4 channel 1 with junk low bits, multi-byte overwrite sweep
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        send_byte(8'h3F, -1, ack);
        chk(ack, "R3", "instr ack junk bits", ack, 1);
        apply_instr(8'h3F);
        for (int i = 0; i < 86; i++) begin
            logic [7:0] v;
            v = 8'(i * 3);
            send_byte(v, -1, ack);
            exp_code[0] = v;
            chk(ack, "R4", "data ack", ack, 1);
            chk(wiper1_code == v, "R4", "wiper1 sweep", wiper1_code, v);
        end
        bus_stop();
        tick(4);
        chk_outs("R3");

        // R3 R4 channel 2
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        send_byte(8'h80, -1, ack);
        apply_instr(8'h80);
        send_byte(8'h5A, -1, ack); exp_code[1] = 8'h5A;
        send_byte(8'hC3, -1, ack); exp_code[1] = 8'hC3;
        bus_stop();
        tick(4);
        chk_outs("R4");

        // R5 R6 read channel 2 with ack then nack, twice (sticky)
        read_check("R5", 3);
        read_check("R5", 1);

        // R5 selection by instruction only
        write_instr(8'h00, "R3");
        read_check("R5", 2);
        chk_outs("R5");

        // R7 shutdown channel 2; stored code still readable
        write_instr(8'hC0, "R7");
        chk_outs("R7");
        read_check("R7", 1);

        // R7 write during shutdown, then clear
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        send_byte(8'hC0, -1, ack);
        apply_instr(8'hC0);
        send_byte(8'h77, -1, ack); exp_code[1] = 8'h77;
        bus_stop();
        tick(4);
        chk_outs("R7");
        write_instr(8'h80, "R7");
        chk(wiper2_code == 8'h77, "R7", "code after clear", wiper2_code, 8'h77);

        // R2 mismatched address: later bytes ignored
        bus_start();
        send_byte({own_addr() ^ 7'h40, 1'b0}, -1, ack);
        chk(!ack, "R2", "mismatch addr", ack, 0);
        send_byte(8'h00, -1, ack);
        chk(!ack, "R2", "ignored instr", ack, 0);
        send_byte(8'h11, -1, ack);
        chk(!ack, "R2", "ignored data", ack, 0);
        bus_stop();
        tick(4);
        chk_outs("R2");

        // R8 repeated start in the middle of a write
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        send_byte(8'h80, -1, ack);
        apply_instr(8'h80);
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        chk(ack, "R8", "addr after repeated start", ack, 1);
        send_byte(8'h00, -1, ack);
        apply_instr(8'h00);
        send_byte(8'h42, -1, ack); exp_code[0] = 8'h42;
        bus_start();
        send_byte({own_addr(), 1'b1}, -1, ack);
        begin
            logic [7:0] v;
            recv_byte(v, 1'b0);
            chk(v == 8'h42, "R8", "read after repeated start", v, 8'h42);
        end
        bus_stop();
        tick(4);
        chk_outs("R8");

        // R9 one-cycle false stop inside a data bit is filtered out
        bus_start();
        send_byte({own_addr(), 1'b0}, -1, ack);
        send_byte(8'h00, -1, ack);
        apply_instr(8'h00);
        send_byte(8'h24, 0, ack);
        chk(ack, "R9", "ack with glitch", ack, 1);
        exp_code[0] = 8'h24;
        bus_stop();
        tick(4);
        chk_outs("R9");

        summary();
    end

endmodule